// File: doc/BRIEF.md
# Header-Aware 32-to-16 Bus Narrower

This block takes a stream of 32-bit words from a synchronous data bus and narrows it for a 16-bit DMA consumer. Each accepted word is split into two 16-bit halves, and both halves are written into an internal FIFO in one cycle. The consumer drains the FIFO through a show-ahead read port. The producer sees a ready signal that stays high only while the FIFO has room for both halves of a word.

While the block narrows the stream, it also looks for frame headers. A word is a header when its upper half equals a programmable 16-bit pattern. Each accepted header raises a one-cycle frame-start pulse and advances a wrapping frame counter. A control input decides whether the header word itself goes into the FIFO or is dropped.

A word offered while ready is low is lost. Losing a word sets a sticky overflow flag, which stays set until the clear input is pulsed.

Top module: `hdr_narrower`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, in_ready=1, frame_start=0, frame_count=0 and ovf_err=0.
- R2: A word is accepted when in_valid and in_ready are both high at a clock edge. An accepted word that is stored becomes two FIFO entries. Bits [15:0] are the first entry and bits [31:16] are the second, so the consumer reads the low half before the high half.
- R3: While fifo_empty is low, rd_data shows the oldest stored entry, and rd_en high at a clock edge removes it. rd_en while fifo_empty is high leaves the FIFO unchanged.
- R4: in_ready is high exactly when at least two of the DEPTH (default 16) entries are free. fifo_full is high exactly when all DEPTH entries are occupied.
- R5: An accepted word whose bits [31:16] equal hdr_pattern is a header. In the cycle after it is accepted, frame_start is high for one cycle and frame_count has increased by one, wrapping modulo 2^CNT_W (default 256). Words that are not headers, including words with the pattern only in bits [15:0], leave both unchanged.
- R6: With fwd_hdr=1, a header is stored like any other word. With fwd_hdr=0, a header is counted but not stored, and the FIFO contents are unchanged.
- R7: A word offered with in_valid=1 while in_ready=0 is discarded and does not count as a header. ovf_err is high from the next cycle onward until a cycle with ovf_clr=1 and no new loss. If a loss and ovf_clr occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming bus word |
| in_valid | input | 1 | in_data is offered this cycle |
| in_ready | output | 1 | FIFO can take both halves of a word |
| hdr_pattern | input | 16 | Pattern compared with the upper half |
| fwd_hdr | input | 1 | 1: store header words, 0: drop them |
| rd_en | input | 1 | Pop the oldest 16-bit entry |
| rd_data | output | 16 | Oldest 16-bit entry (show-ahead) |
| fifo_empty | output | 1 | No entries stored |
| fifo_full | output | 1 | All entries occupied |
| frame_start | output | 1 | One-cycle pulse after an accepted header |
| frame_count | output | 8 | Number of headers seen, wrapping |
| ovf_err | output | 1 | Sticky flag for a lost word |
| ovf_clr | input | 1 | Clears ovf_err |

## Verification
The vector table mixes several kinds of word:
- plain data words;
- headers with forwarding on and headers with forwarding off;
- a word that differs from the pattern only in its lowest upper-half bit;
- a word that carries the pattern only in its low half;
- a word whose two halves both equal the pattern.

These words separate three things: a compare on the correct half from a compare on the wrong half or a loose compare, dropping a header from dropping every word, and the low-first order from a swapped order. Directed sequences then test the FIFO boundaries:
- filling the FIFO to exactly one word below capacity and then to capacity, which separates the ready threshold from the full threshold;
- offering a header while stalled, which shows that a lost word is neither stored nor counted;
- driving set and clear of the overflow flag in the same cycle;
- popping while empty;
- passing 256 dropped headers through the counter to show that it wraps.

// File: rtl/hnar_pkg.sv
package hnar_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int lanes_of(input int wide, input int narrow);
      return wide / narrow;
   endfunction

endpackage

// File: rtl/hnar_fifo.sv
module hnar_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LANES*W-1:0] wr_data,
   input  logic               rd_en,
   output logic [W-1:0]       rd_data,
   output logic               empty,
   output logic               full,
   output logic               room,
   output logic [$clog2(DEPTH):0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [W-1:0]  lane [LANES];
   logic          do_rd;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = wr_data[g*W +: W];
   end

   assign do_rd = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            mem[AW'(wptr + AW'(i))] <= lane[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en) wptr <= AW'(wptr + AW'(LANES));
         if (do_rd) rptr <= AW'(rptr + 1'b1);
         count <= CW'(count + (wr_en ? CW'(LANES) : CW'(0)) - (do_rd ? CW'(1) : CW'(0)));
      end
   end

   assign rd_data = mem[rptr];
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign room    = (CW'(DEPTH) - count) >= CW'(LANES);

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r4_write_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> room);
   a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_en) |=> (count == '0) && $stable(rptr));
endmodule

// File: rtl/hnar_hdr.sv
module hnar_hdr #(
   parameter int HW    = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [HW-1:0]    field,
   input  logic [HW-1:0]    pattern,
   output logic             hit,
   output logic             frame_start,
   output logic [CNT_W-1:0] frame_count
);
   assign hit = (field == pattern);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_start <= 1'b0;
         frame_count <= '0;
      end else begin
         frame_start <= take && hit;
         if (take && hit) frame_count <= CNT_W'(frame_count + 1'b1);
      end
   end

   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> frame_count == CNT_W'($past(frame_count) + 1'b1));
   a_r5_count_still: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |-> $stable(frame_count));
endmodule

// File: rtl/hnar_sticky.sv
module hnar_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
endmodule

// File: rtl/hdr_narrower.sv
module hdr_narrower #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 16,
   parameter int DEPTH = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OUT_W-1:0] hdr_pattern,
   input  logic             fwd_hdr,
   input  logic             rd_en,
   output logic [OUT_W-1:0] rd_data,
   output logic             fifo_empty,
   output logic             fifo_full,
   output logic             frame_start,
   output logic [CNT_W-1:0] frame_count,
   output logic             ovf_err,
   input  logic             ovf_clr
);
   import hnar_pkg::*;

   localparam int LANES = lanes_of(IN_W, OUT_W);
   localparam int CW    = $clog2(DEPTH) + 1;

   if (IN_W % OUT_W != 0 || LANES < 2) begin : g_bad_width
      $error("IN_W must be a multiple of OUT_W, at least twice it");
   end
   if (!is_pow2(DEPTH) || DEPTH < 2 * LANES) begin : g_bad_depth
      $error("DEPTH must be a power of two and hold two words");
   end

   logic          room, take, hit, wr_en, lost;
   logic [CW-1:0] count;

   assign take     = in_valid && room;
   assign lost     = in_valid && !room;
   assign wr_en    = take && (!hit || fwd_hdr);
   assign in_ready = room;

   hnar_hdr #(.HW(OUT_W), .CNT_W(CNT_W)) u_hdr (
      .clk(clk), .rst_n(rst_n), .take(take),
      .field(in_data[IN_W-1 -: OUT_W]), .pattern(hdr_pattern),
      .hit(hit), .frame_start(frame_start), .frame_count(frame_count)
   );

   hnar_fifo #(.W(OUT_W), .DEPTH(DEPTH), .LANES(LANES)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data),
      .rd_en(rd_en), .rd_data(rd_data), .empty(fifo_empty),
      .full(fifo_full), .room(room), .count(count)
   );

   hnar_sticky u_ovf (
      .clk(clk), .rst_n(rst_n), .set(lost), .clr(ovf_clr), .flag(ovf_err)
   );

   a_r6_drop_keeps_fifo: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !fwd_hdr && in_data[IN_W-1 -: OUT_W] == hdr_pattern
       && (fifo_empty || !rd_en)) |=> $stable(count));
   a_r7_lost_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> !frame_start && ovf_err);
   a_r4_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !in_ready);
endmodule

// File: tb/tb_hdr_narrower.sv
module tb_hdr_narrower;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [15:0] PAT = 16'hA5C3;
   localparam int NV = 8;
   // columns: {fwd_hdr, word, expected header flag}
   localparam logic [33:0] VEC [NV] = '{
      {1'b1, 32'h1234_5678, 1'b0},
      {1'b1, 32'hA5C3_0001, 1'b1},
      {1'b0, 32'hA5C3_0002, 1'b1},
      {1'b0, 32'hA5C2_FFFF, 1'b0},
      {1'b1, 32'h0000_A5C3, 1'b0},
      {1'b0, 32'hFFFF_0000, 1'b0},
      {1'b0, 32'hA5C3_A5C3, 1'b1},
      {1'b1, 32'hDEAD_BEEF, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] in_data = '0;
   logic in_valid = 1'b0, fwd_hdr = 1'b1, rd_en = 1'b0, ovf_clr = 1'b0;
   logic in_ready, fifo_empty, fifo_full, frame_start, ovf_err;
   logic [15:0] rd_data;
   logic [7:0]  frame_count;
   int total = 0, bad = 0;
   logic [7:0] exp_cnt = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdr_narrower dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .hdr_pattern(PAT), .fwd_hdr(fwd_hdr),
      .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
      .fifo_full(fifo_full), .frame_start(frame_start),
      .frame_count(frame_count), .ovf_err(ovf_err), .ovf_clr(ovf_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one word for one edge; sample at the following falling edge
   task automatic push(input logic [31:0] w, input logic f);
      in_data = w; fwd_hdr = f; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pop_check(input string req, input logic [15:0] exp);
      check(req, {16'h0, rd_data}, {16'h0, exp});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 empty", fifo_empty, 1);
      check("R1 full", fifo_full, 0);
      check("R1 ready", in_ready, 1);
      check("R1 frame_start", frame_start, 0);
      check("R1 frame_count", frame_count, 0);
      check("R1 ovf_err", ovf_err, 0);

      // table walk: R2, R5, R6
      for (int i = 0; i < NV; i++) begin
         logic [31:0] w;
         logic f, h;
         f = VEC[i][33]; w = VEC[i][32:1]; h = VEC[i][0];
         push(w, f);
         if (h) exp_cnt++;
         check("R5 frame_start", frame_start, h);
         check("R5 frame_count", frame_count, exp_cnt);
         if (!h || f) begin
            pop_check("R2 low half", w[15:0]);
            pop_check("R2 high half", w[31:16]);
         end
         check("R6 empty after vector", fifo_empty, 1);
         @(negedge clk);
         check("R5 pulse one cycle", frame_start, 0);
      end

      // R4: seven words leave two free, ready stays high
      for (int i = 0; i < 7; i++) push(32'h0100_0200 + 32'(i), 1'b1);
      check("R4 ready at two free", in_ready, 1);
      check("R4 not full", fifo_full, 0);
      push(32'h0100_0207, 1'b1);
      check("R4 full", fifo_full, 1);
      check("R4 ready low", in_ready, 0);

      // R7 lost header word while stalled
      push({PAT, 16'h7777}, 1'b1);
      check("R7 ovf set", ovf_err, 1);
      check("R7 lost not a header", frame_start, 0);
      check("R7 count unchanged", frame_count, exp_cnt);
      repeat (3) @(negedge clk);
      check("R7 sticky", ovf_err, 1);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R7 cleared", ovf_err, 0);
      ovf_clr = 1'b1; in_valid = 1'b1; in_data = 32'h1111_2222;
      @(negedge clk);
      ovf_clr = 1'b0; in_valid = 1'b0;
      check("R7 set beats clear", ovf_err, 1);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R7 cleared again", ovf_err, 0);

      // drain full FIFO: R3 order, lost words absent
      for (int i = 0; i < 8; i++) begin
         pop_check("R3 drain low", 16'h0200 + 16'(i));
         pop_check("R3 drain high", 16'h0100);
      end
      check("R3 empty after drain", fifo_empty, 1);

      // R3 pop on empty ignored
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      check("R3 empty pop", fifo_empty, 1);
      push(32'hCAFE_F00D, 1'b1);
      pop_check("R3 after empty pop low", 16'hF00D);
      pop_check("R3 after empty pop high", 16'hCAFE);
      check("R3 empty end", fifo_empty, 1);

      // R5 wrap via 256 dropped headers
      for (int i = 0; i < 256; i++) push({PAT, 16'(i)}, 1'b0);
      check("R5 wrap count", frame_count, exp_cnt);
      check("R6 dropped headers not stored", fifo_empty, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule